// File: doc/BRIEF.md
# Message-Driven Shared Interrupt Pending Controller

This block keeps the pending state of the shared peripheral interrupts in an interrupt distributor when those interrupts are raised and dropped by register writes instead of by wires. A bus master writes an interrupt number into one of four write-only ports. These are set or clear, each with a non-secure and a secure variant. The block decides whether the write is allowed and then sets or clears one bit of the pending vector.

Each write is checked against several things: the interrupt's current pending state, whether the access is secure, a per-interrupt group bit, a per-interrupt two-bit non-secure access level, and a global security-disable bit. A separate configuration port loads the group bits, the access levels and the security-disable bit. A constant capability word reports that message-driven interrupts are supported, along with the number of 32-interrupt lines implemented.

Top module: `msgint_pend_ctrl`

## Requirements
- R1: The target ID is `wr_data[9:0]`. Higher data bits are ignored. Only IDs from 32 to NUM_IRQ-1 are valid, and a write naming any other ID leaves `pend_o` unchanged. Bit i of `pend_o` is ID 32+i.
- R2: A write counts only on a clock edge where `wr_en` is 1, and an accepted write shows on `pend_o` right after that edge. A set write never clears a bit and a clear write never sets one. `wr_sel` is encoded as 0 = non-secure set, 1 = non-secure clear, 2 = secure set, 3 = secure clear.
- R3: A non-secure set write does nothing if the ID is already pending. It also does nothing if the access is non-secure (`wr_secure`=0), the interrupt is secure (group bit 0) and its access level is 0. A secure access, or an interrupt with group bit 1, may set the bit.
- R4: A non-secure clear write does nothing if the ID is not pending.
- R5: A non-secure clear write does nothing if a non-secure access targets a secure interrupt whose access level is below 2.
- R6: While the security-disable bit is 1, secure set and secure clear writes have no effect.
- R7: Secure set and secure clear writes have no effect when `wr_secure` is 0. Otherwise they behave like set and clear, and need no group or access-level check.
- R8: `caps_o` bit 16 is 1, bits [4:0] hold ceil(NUM_IRQ/32)-1, and all other bits are 0.
- R9: A `cfg_we` write stores `cfg_grp` and `cfg_acc` for the valid ID `cfg_id`. A `cfg_sd_we` write stores `cfg_sd`. Reset clears all pending bits, group bits, access levels and the security-disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Set/clear write strobe |
| wr_sel | input | 2 | Write target: 0 NS set, 1 NS clear, 2 S set, 3 S clear |
| wr_data | input | 32 | Write data; ID in [9:0] |
| wr_secure | input | 1 | 1 = secure access |
| cfg_we | input | 1 | Per-interrupt configuration write strobe |
| cfg_id | input | 10 | Interrupt ID for configuration |
| cfg_grp | input | 1 | Group bit: 1 = non-secure interrupt |
| cfg_acc | input | 2 | Non-secure access level |
| cfg_sd_we | input | 1 | Security-disable write strobe |
| cfg_sd | input | 1 | Security-disable value |
| pend_o | output | NUM_IRQ-32 | Pending vector, bit i = ID 32+i |
| caps_o | output | 32 | Capability word |

## Verification
An accepted write changes `pend_o` one register stage after the strobe, on the edge that samples `wr_en`. The bench drives every write on a falling edge, drops the strobe on the next falling edge, and compares `pend_o` at that point. Ignored writes are detected because `pend_o` is unchanged at the same sampling point. Configuration writes take effect on their sampling edge, so every configuration write is finished before any write that depends on it is driven. `caps_o` is constant and is checked in the reset state.

// File: rtl/msgp_pkg.sv
package msgp_pkg;
  localparam int ID_W         = 10;
  localparam int SPI_BASE     = 32;
  localparam int CAPS_MSG_BIT = 16;
  localparam int ACC_W        = 2;

  typedef enum logic [1:0] {
    SEL_NS_SET = 2'd0,
    SEL_NS_CLR = 2'd1,
    SEL_S_SET  = 2'd2,
    SEL_S_CLR  = 2'd3
  } wsel_e;
endpackage

// File: rtl/msgp_cfg.sv
module msgp_cfg
  import msgp_pkg::*;
#(
  parameter int NUM_SPI = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ID_W-1:0]          cfg_id,
  input  logic                     cfg_grp,
  input  logic [ACC_W-1:0]         cfg_acc,
  input  logic                     cfg_sd_we,
  input  logic                     cfg_sd,
  output logic [NUM_SPI-1:0]       grp_q,
  output logic [ACC_W*NUM_SPI-1:0] acc_q,
  output logic                     sd_q
);
  logic [NUM_SPI-1:0]       slot_hit;
  logic [NUM_SPI-1:0]       grp_d;
  logic [ACC_W*NUM_SPI-1:0] acc_d;
  logic                     sd_d;

  // one decoder compare per slot
  for (genvar i = 0; i < NUM_SPI; i++) begin : g_slot
    assign slot_hit[i] = cfg_we && (cfg_id == ID_W'(SPI_BASE + i));

    always_comb begin
      grp_d[i]                 = grp_q[i];
      acc_d[i*ACC_W +: ACC_W]  = acc_q[i*ACC_W +: ACC_W];
      if (slot_hit[i]) begin
        grp_d[i]                = cfg_grp;
        acc_d[i*ACC_W +: ACC_W] = cfg_acc;
      end
    end
  end

  always_comb begin
    sd_d = sd_q;
    if (cfg_sd_we) sd_d = cfg_sd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      acc_q <= '0;
      sd_q  <= 1'b0;
    end else begin
      grp_q <= grp_d;
      acc_q <= acc_d;
      sd_q  <= sd_d;
    end
  end
endmodule

// File: rtl/msgp_qual.sv
module msgp_qual
  import msgp_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_SPI = 32,
  parameter int IDX_W   = 5
) (
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [31:0]              wr_data,
  input  logic                     wr_secure,
  input  logic [NUM_SPI-1:0]       pend_q,
  input  logic [NUM_SPI-1:0]       grp_q,
  input  logic [ACC_W*NUM_SPI-1:0] acc_q,
  input  logic                     sd_q,
  output logic                     do_set,
  output logic                     do_clr,
  output logic [IDX_W-1:0]         tgt_idx
);
  logic [ID_W-1:0]  id;
  logic [ID_W-1:0]  off;
  logic             id_ok;
  logic             cur_pend;
  logic             cur_grp;
  logic [ACC_W-1:0] cur_acc;
  logic             ns_to_sec;
  wsel_e            sel;

  assign id    = wr_data[ID_W-1:0];
  assign sel   = wsel_e'(wr_sel);
  assign off   = id - ID_W'(SPI_BASE);
  assign id_ok = ({1'b0, id} >= (ID_W+1)'(SPI_BASE)) &&
                 ({1'b0, id} <  (ID_W+1)'(NUM_IRQ));

  always_comb begin
    tgt_idx = '0;
    if (id_ok) tgt_idx = off[IDX_W-1:0];
  end

  assign cur_pend  = pend_q[tgt_idx];
  assign cur_grp   = grp_q[tgt_idx];
  assign cur_acc   = acc_q[tgt_idx*ACC_W +: ACC_W];
  assign ns_to_sec = !wr_secure && !cur_grp;

  always_comb begin
    do_set = 1'b0;
    do_clr = 1'b0;
    if (wr_en && id_ok) begin
      unique case (sel)
        SEL_NS_SET: do_set = !cur_pend && !(ns_to_sec && (cur_acc == 2'd0));
        SEL_NS_CLR: do_clr =  cur_pend && !(ns_to_sec && (cur_acc < 2'd2));
        SEL_S_SET:  do_set = !sd_q && wr_secure && !cur_pend;
        SEL_S_CLR:  do_clr = !sd_q && wr_secure &&  cur_pend;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msgp_pend.sv
module msgp_pend #(
  parameter int NUM_SPI = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               do_set,
  input  logic               do_clr,
  input  logic [IDX_W-1:0]   tgt_idx,
  output logic [NUM_SPI-1:0] pend_q
);
  logic [NUM_SPI-1:0] pend_d;
  logic [NUM_SPI-1:0] bit_en;

  for (genvar i = 0; i < NUM_SPI; i++) begin : g_bit
    assign bit_en[i] = (do_set || do_clr) && (tgt_idx == IDX_W'(i));

    always_comb begin
      pend_d[i] = pend_q[i];
      if (bit_en[i]) pend_d[i] = do_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/msgint_pend_ctrl.sv
module msgint_pend_ctrl
  import msgp_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [31:0]             wr_data,
  input  logic                    wr_secure,
  input  logic                    cfg_we,
  input  logic [9:0]              cfg_id,
  input  logic                    cfg_grp,
  input  logic [1:0]              cfg_acc,
  input  logic                    cfg_sd_we,
  input  logic                    cfg_sd,
  output logic [NUM_IRQ-33:0]     pend_o,
  output logic [31:0]             caps_o
);
  localparam int NUM_SPI = NUM_IRQ - SPI_BASE;
  localparam int IDX_W   = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
  localparam int LINES   = (NUM_IRQ + 31) / 32 - 1;

  logic [NUM_SPI-1:0]       grp_q;
  logic [ACC_W*NUM_SPI-1:0] acc_q;
  logic                     sd_q;
  logic [NUM_SPI-1:0]       pend_q;
  logic                     do_set;
  logic                     do_clr;
  logic [IDX_W-1:0]         tgt_idx;

  msgp_cfg #(.NUM_SPI(NUM_SPI)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_grp(cfg_grp), .cfg_acc(cfg_acc),
    .cfg_sd_we(cfg_sd_we), .cfg_sd(cfg_sd),
    .grp_q(grp_q), .acc_q(acc_q), .sd_q(sd_q)
  );

  msgp_qual #(.NUM_IRQ(NUM_IRQ), .NUM_SPI(NUM_SPI), .IDX_W(IDX_W)) u_qual (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_secure(wr_secure),
    .pend_q(pend_q), .grp_q(grp_q), .acc_q(acc_q), .sd_q(sd_q),
    .do_set(do_set), .do_clr(do_clr), .tgt_idx(tgt_idx)
  );

  msgp_pend #(.NUM_SPI(NUM_SPI), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .do_set(do_set), .do_clr(do_clr), .tgt_idx(tgt_idx),
    .pend_q(pend_q)
  );

  assign pend_o = pend_q;

  always_comb begin
    caps_o               = '0;
    caps_o[CAPS_MSG_BIT] = 1'b1;
    caps_o[4:0]          = 5'(LINES);
  end
endmodule

// File: rtl/msgp_chk.sv
module msgp_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_SPI = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [31:0]        wr_data,
  input logic               wr_secure,
  input logic               sd_q,
  input logic [NUM_SPI-1:0] pend_o
);
  logic id_bad;
  assign id_bad = ({1'b0, wr_data[9:0]} < 11'd32) ||
                  ({1'b0, wr_data[9:0]} >= 11'(NUM_IRQ));

  // R1
  bad_id_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && id_bad) |=> $stable(pend_o));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend_o));

  // R2
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones(pend_o ^ $past(pend_o)) <= 1));

  // R2
  set_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel[0]) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  // R2
  clear_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[0]) |=> ((pend_o | $past(pend_o)) == $past(pend_o)));

  // R6
  sd_blocks_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[1] && sd_q) |=> $stable(pend_o));

  // R7
  ns_blocks_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[1] && !wr_secure) |=> $stable(pend_o));
endmodule

bind msgint_pend_ctrl msgp_chk #(.NUM_IRQ(NUM_IRQ), .NUM_SPI(NUM_SPI)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .wr_secure(wr_secure), .sd_q(sd_q), .pend_o(pend_o)
);

// File: tb/sim_msgint_pend_ctrl.sv
module sim_msgint_pend_ctrl;
  localparam int NIRQ = 64;
  localparam int NSPI = NIRQ - 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_sel = '0;
  logic [31:0]     wr_data = '0;
  logic            wr_secure = 1'b0;
  logic            cfg_we = 1'b0;
  logic [9:0]      cfg_id = '0;
  logic            cfg_grp = 1'b0;
  logic [1:0]      cfg_acc = '0;
  logic            cfg_sd_we = 1'b0;
  logic            cfg_sd = 1'b0;
  logic [NSPI-1:0] pend_o;
  logic [31:0]     caps_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msgint_pend_ctrl #(.NUM_IRQ(NIRQ)) u0 (.*);

  typedef struct packed {
    logic [1:0]  sel;
    logic        sec;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // config before table: ID40 grp1; ID41 grp0 acc0; ID42 grp0 acc1; ID43 grp0 acc2
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 32'd40,        32'h0000_0100, 8'd3}, // R3 non-secure group, set
    '{2'd0, 1'b0, 32'd41,        32'h0000_0100, 8'd3}, // R3 acc0 blocks NS set
    '{2'd0, 1'b0, 32'd42,        32'h0000_0500, 8'd3}, // R3 acc1 allows NS set
    '{2'd1, 1'b0, 32'd42,        32'h0000_0500, 8'd5}, // R5 acc1 blocks NS clear
    '{2'd0, 1'b0, 32'd43,        32'h0000_0D00, 8'd3},
    '{2'd1, 1'b0, 32'd43,        32'h0000_0500, 8'd5}, // R5 acc2 allows NS clear
    '{2'd0, 1'b1, 32'd41,        32'h0000_0700, 8'd3}, // R3 secure access bypass
    '{2'd0, 1'b1, 32'd31,        32'h0000_0700, 8'd1}, // R1 below range
    '{2'd0, 1'b1, 32'd64,        32'h0000_0700, 8'd1}, // R1 at max
    '{2'd1, 1'b1, 32'd44,        32'h0000_0700, 8'd4}, // R4 clear not pending
    '{2'd2, 1'b0, 32'd44,        32'h0000_0700, 8'd7}, // R7 NS access to S set
    '{2'd2, 1'b1, 32'd44,        32'h0000_1700, 8'd7},
    '{2'd3, 1'b1, 32'd40,        32'h0000_1600, 8'd7},
    '{2'd3, 1'b0, 32'd41,        32'h0000_1600, 8'd7}, // R7 NS access to S clear
    '{2'd1, 1'b1, 32'd41,        32'h0000_1400, 8'd2}, // R2 clear path
    '{2'd2, 1'b1, 32'd63,        32'h8000_1400, 8'd1}, // R1 top ID
    '{2'd0, 1'b1, 32'd32,        32'h8000_1401, 8'd1}, // R1 bottom ID
    '{2'd2, 1'b1, 32'hFFFF_FC2D, 32'h8000_3401, 8'd1}  // R1 high bits ignored (ID45)
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] sel, input logic sec, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_secure = sec; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_cfg(input int id, input logic g, input logic [1:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_id = 10'(id); cfg_grp = g; cfg_acc = a;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_sd(input logic v);
    @(negedge clk);
    cfg_sd_we = 1'b1; cfg_sd = v;
    @(negedge clk);
    cfg_sd_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(9, 32'(pend_o), 32'h0, "pending after reset");
    // R8 capability word
    chk(8, caps_o, 32'h0001_0001, "capability word");

    // R9 configuration loads
    do_cfg(40, 1'b1, 2'd0);
    do_cfg(41, 1'b0, 2'd0);
    do_cfg(42, 1'b0, 2'd1);
    do_cfg(43, 1'b0, 2'd2);
    do_cfg(20, 1'b1, 2'd3); // invalid config ID, ignored

    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i].sel, VEC[i].sec, VEC[i].data);
      chk(int'(VEC[i].req), 32'(pend_o), VEC[i].exp, $sformatf("vector %0d", i));
    end

    // R2 strobe low: data present but no write
    @(negedge clk);
    wr_sel = 2'd0; wr_secure = 1'b1; wr_data = 32'd50;
    @(negedge clk);
    wr_data = '0;
    chk(2, 32'(pend_o), 32'h8000_3401, "no strobe");

    // R6 security disable blocks secure view
    do_sd(1'b1);
    do_wr(2'd3, 1'b1, 32'd32);
    chk(6, 32'(pend_o), 32'h8000_3401, "S clear while disabled");
    do_wr(2'd2, 1'b1, 32'd46);
    chk(6, 32'(pend_o), 32'h8000_3401, "S set while disabled");
    do_wr(2'd1, 1'b1, 32'd32);
    chk(6, 32'(pend_o), 32'h8000_3400, "NS clear while disabled");
    do_sd(1'b0);
    do_wr(2'd2, 1'b1, 32'd46);
    chk(6, 32'(pend_o), 32'h8000_7400, "S set after re-enable");

    // R9 reset mid-run clears pending and config
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(9, 32'(pend_o), 32'h0, "async reset");
    @(negedge clk);
    rst_n = 1'b1;
    do_wr(2'd0, 1'b0, 32'd40);
    chk(9, 32'(pend_o), 32'h0, "group cleared by reset");
    do_wr(2'd0, 1'b1, 32'd40);
    chk(9, 32'(pend_o), 32'h0000_0100, "secure set after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule